// File: doc/BRIEF.md
# Multi-Buffer Packet FIFO with Whole-Buffer Handoff

This block sits between a USB-side packet engine and an external 16-bit I/O port. It holds a small ring of packet buffers, two to four of them, each `DEPTH` words of `WIDTH` bits. With the defaults a buffer is 256 x 16, which is exactly one 512-byte high-speed bulk packet. The USB side fills one buffer at a time. When the packet ends, the whole buffer changes owner to the I/O side in a single clock, and no words are copied. The I/O side drains that buffer. Reading its final word hands the buffer back to the USB side.

Both data ports use valid/ready handshakes.
- A word moves on a rising edge where valid and ready are both high.
- `u_ready` is low whenever the buffer the USB side would fill next is still owned by the I/O side. This is the only back-pressure the packet engine sees.
- `o_valid` is high whenever the buffer the I/O side would drain next is owned by the I/O side. The external port may hold `o_ready` low for as long as it likes, and the data and flags stay put.
- Both sides step through the buffers in the same round-robin order, so packets leave in the order they were committed.

Plain status pins report three things: no buffer waiting, every buffer waiting, and whether the active I/O buffer still holds at least a programmable number of unread words. A sticky pin records any write that was offered while no buffer was free.

Top module: `efifo_ep`

## Requirements
- R1: After reset `o_valid`=0, `u_ready`=1, `io_empty`=1, `io_full`=0, `io_level`=0 and `ovf`=0.
- R2: Every word accepted on the USB side leaves the I/O side unchanged, and in the order it was accepted.
- R3: A write with `u_last`=1 commits the buffer. For a packet of k words (1 <= k <= DEPTH), the I/O side presents exactly k words and raises `o_last` only on the k-th.
- R4: Accepting word number DEPTH of a buffer commits that buffer even when `u_last`=0. The next word accepted starts the following buffer.
- R5: A committed buffer is visible on `o_valid` (and `io_empty` falls) in the cycle after the committing edge. The edge that reads the `o_last` word returns the buffer to the USB side, so `io_full` is low in the next cycle.
- R6: Buffers are used round-robin on both sides. NBUF packets can be committed before `u_ready` falls, and they are read out in commit order.
- R7: `io_full`=1 exactly when all NBUF buffers are owned by the I/O side, and then `u_ready`=0.
- R8: `io_level`=1 exactly when a buffer is available to the I/O side and its unread word count (committed length minus words already read) is greater than or equal to `cfg_thresh`.
- R9: `u_valid`=1 while `u_ready`=0 stores nothing. `ovf` is high from the next cycle and stays high until reset.
- R10: `io_empty`=1 exactly when no buffer is owned by the I/O side, which is when `o_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thresh | input | CW = log2(DEPTH)+1 | Unread-word threshold for `io_level` |
| u_valid | input | 1 | USB side offers a word |
| u_ready | output | 1 | A free buffer can take the word |
| u_data | input | WIDTH | USB-side write data |
| u_last | input | 1 | Offered word ends the packet |
| o_valid | output | 1 | A committed buffer has a word for the I/O side |
| o_ready | input | 1 | I/O side takes the word |
| o_data | output | WIDTH | I/O-side read data |
| o_last | output | 1 | Presented word is the last of its buffer |
| io_empty | output | 1 | No buffer owned by the I/O side |
| io_full | output | 1 | All buffers owned by the I/O side |
| io_level | output | 1 | Active I/O buffer holds at least `cfg_thresh` unread words |
| ovf | output | 1 | Sticky: a write was refused |

## Verification
All outputs except `ovf` are combinational functions of state registered on the previous rising edge, together with `cfg_thresh`. A commit or a buffer release is therefore visible one edge after the handshake that caused it, and `ovf` rises one edge after the refused attempt. The bench drives inputs on the falling edge and samples 1 ns later. Each expected value is therefore taken in the first half-cycle after the edge that should produce it, never one edge late. The bench sweeps every packet length, every threshold from 0 to DEPTH+1, the full-buffer auto-commit and the full-ring overflow on a three-buffer, eight-word configuration.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  localparam int EF_WIDTH = 16;
  localparam int EF_DEPTH = 256;
  localparam int EF_NBUF  = 4;

  // which side currently holds a buffer
  typedef enum logic {SIDE_USB = 1'b0, SIDE_IO = 1'b1} side_e;
endpackage

// File: rtl/efifo_store.sv
module efifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int NBUF  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [AW-1:0]    wptr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ridx,
  input  logic [AW-1:0]    rptr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] bank_rd [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    logic [WIDTH-1:0] words [DEPTH];
    always_ff @(posedge clk) begin
      if (we && widx == IW'(g)) words[wptr] <= wdata;
    end
    assign bank_rd[g] = words[rptr];
  end

  assign rdata = bank_rd[ridx];
endmodule

// File: rtl/efifo_owner.sv
module efifo_owner
  import efifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NBUF  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            u_valid,
  input  logic            u_last,
  input  logic            o_ready,
  output logic            u_ready,
  output logic            u_fire,
  output logic [IW-1:0]   wr_idx,
  output logic [AW-1:0]   wr_ptr,
  output logic            o_valid,
  output logic            o_last,
  output logic [IW-1:0]   rd_idx,
  output logic [AW-1:0]   rd_ptr,
  output logic [NBUF-1:0] own_io,
  output logic [CW-1:0]   rd_left
);
  side_e         own_q [NBUF];
  logic [CW-1:0] len_q [NBUF];
  logic [IW-1:0] wr_idx_q, rd_idx_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cur_len;
  logic          wr_commit, o_fire, rd_done;

  assign u_ready   = (own_q[wr_idx_q] == SIDE_USB);
  assign u_fire    = u_valid && u_ready;
  assign wr_commit = u_fire && (u_last || wr_ptr_q == AW'(DEPTH - 1));

  assign o_valid = (own_q[rd_idx_q] == SIDE_IO);
  assign cur_len = len_q[rd_idx_q];
  assign rd_left = cur_len - {1'b0, rd_ptr_q};
  assign o_last  = ({1'b0, rd_ptr_q} == cur_len - CW'(1));
  assign o_fire  = o_valid && o_ready;
  assign rd_done = o_fire && o_last;

  for (genvar g = 0; g < NBUF; g++) begin : g_own
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q[g] <= SIDE_USB;
        len_q[g] <= '0;
      end else if (wr_commit && wr_idx_q == IW'(g)) begin
        own_q[g] <= SIDE_IO;
        len_q[g] <= {1'b0, wr_ptr_q} + CW'(1);
      end else if (rd_done && rd_idx_q == IW'(g)) begin
        own_q[g] <= SIDE_USB;
      end
    end
    assign own_io[g] = (own_q[g] == SIDE_IO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      wr_ptr_q <= '0;
    end else if (wr_commit) begin
      wr_idx_q <= (wr_idx_q == IW'(NBUF - 1)) ? '0 : wr_idx_q + IW'(1);
      wr_ptr_q <= '0;
    end else if (u_fire) begin
      wr_ptr_q <= wr_ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q <= '0;
      rd_ptr_q <= '0;
    end else if (rd_done) begin
      rd_idx_q <= (rd_idx_q == IW'(NBUF - 1)) ? '0 : rd_idx_q + IW'(1);
      rd_ptr_q <= '0;
    end else if (o_fire) begin
      rd_ptr_q <= rd_ptr_q + AW'(1);
    end
  end

  assign wr_idx = wr_idx_q;
  assign wr_ptr = wr_ptr_q;
  assign rd_idx = rd_idx_q;
  assign rd_ptr = rd_ptr_q;
endmodule

// File: rtl/efifo_flags.sv
module efifo_flags #(
  parameter int DEPTH = 256,
  parameter int NBUF  = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] own_io,
  input  logic [CW-1:0]   rd_left,
  input  logic [CW-1:0]   cfg_thresh,
  input  logic            u_valid,
  input  logic            u_ready,
  output logic            io_empty,
  output logic            io_full,
  output logic            io_level,
  output logic            ovf
);
  logic ovf_q;

  assign io_empty = ~|own_io;
  assign io_full  = &own_io;
  assign io_level = !io_empty && (rd_left >= cfg_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (u_valid && !u_ready) ovf_q <= 1'b1;
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/efifo_ep.sv
module efifo_ep #(
  parameter int WIDTH = efifo_pkg::EF_WIDTH,
  parameter int DEPTH = efifo_pkg::EF_DEPTH,
  parameter int NBUF  = efifo_pkg::EF_NBUF,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_thresh,
  input  logic             u_valid,
  output logic             u_ready,
  input  logic [WIDTH-1:0] u_data,
  input  logic             u_last,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [WIDTH-1:0] o_data,
  output logic             o_last,
  output logic             io_empty,
  output logic             io_full,
  output logic             io_level,
  output logic             ovf
);
  logic            u_fire;
  logic [IW-1:0]   wr_idx, rd_idx;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [NBUF-1:0] own_io;
  logic [CW-1:0]   rd_left;

  efifo_owner #(.DEPTH(DEPTH), .NBUF(NBUF)) u_owner (
    .clk(clk), .rst_n(rst_n), .u_valid(u_valid), .u_last(u_last),
    .o_ready(o_ready), .u_ready(u_ready), .u_fire(u_fire),
    .wr_idx(wr_idx), .wr_ptr(wr_ptr), .o_valid(o_valid), .o_last(o_last),
    .rd_idx(rd_idx), .rd_ptr(rd_ptr), .own_io(own_io), .rd_left(rd_left)
  );

  efifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NBUF(NBUF)) u_store (
    .clk(clk), .we(u_fire), .widx(wr_idx), .wptr(wr_ptr), .wdata(u_data),
    .ridx(rd_idx), .rptr(rd_ptr), .rdata(o_data)
  );

  efifo_flags #(.DEPTH(DEPTH), .NBUF(NBUF)) u_flags (
    .clk(clk), .rst_n(rst_n), .own_io(own_io), .rd_left(rd_left),
    .cfg_thresh(cfg_thresh), .u_valid(u_valid), .u_ready(u_ready),
    .io_empty(io_empty), .io_full(io_full), .io_level(io_level), .ovf(ovf)
  );
endmodule

// File: rtl/efifo_ep_chk.sv
module efifo_ep_chk (
  input logic clk,
  input logic rst_n,
  input logic u_valid,
  input logic u_ready,
  input logic u_last,
  input logic o_valid,
  input logic o_ready,
  input logic o_last,
  input logic io_empty,
  input logic io_full,
  input logic io_level,
  input logic ovf
);
  // R7
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_full |-> !u_ready);

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && !u_ready) |=> ovf);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R10
  empty_matches_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_empty != o_valid);

  // R5
  commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && u_ready && u_last) |=> o_valid);

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && o_last) |=> !io_full);

  // R8
  level_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_level |-> o_valid);
endmodule

bind efifo_ep efifo_ep_chk u_chk (
  .clk(clk), .rst_n(rst_n), .u_valid(u_valid), .u_ready(u_ready),
  .u_last(u_last), .o_valid(o_valid), .o_ready(o_ready), .o_last(o_last),
  .io_empty(io_empty), .io_full(io_full), .io_level(io_level), .ovf(ovf)
);

// File: tb/tb_efifo_ep.sv
module tb_efifo_ep;
  localparam int W  = 16;
  localparam int D  = 8;
  localparam int NB = 3;
  localparam int CW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] cfg_thresh;
  logic u_valid, u_ready, u_last;
  logic [W-1:0] u_data;
  logic o_valid, o_ready, o_last;
  logic [W-1:0] o_data;
  logic io_empty, io_full, io_level, ovf;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  efifo_ep #(.WIDTH(W), .DEPTH(D), .NBUF(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
    .u_valid(u_valid), .u_ready(u_ready), .u_data(u_data), .u_last(u_last),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last),
    .io_empty(io_empty), .io_full(io_full), .io_level(io_level), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input int base, input bit mark);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      u_valid = 1'b1;
      u_data  = W'(base + k);
      u_last  = mark && (k == n - 1);
      #1 chk(u_ready == 1'b1, "R7 ready while free", int'(u_ready), 1);
      @(posedge clk);
    end
    @(negedge clk);
    u_valid = 1'b0;
    u_last  = 1'b0;
  endtask

  task automatic pop(input int n, input int base, input int th);
    cfg_thresh = CW'(th);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      o_ready = 1'b1;
      #1;
      chk(o_valid == 1'b1, "R5 valid", int'(o_valid), 1);
      chk(o_data == W'(base + k), "R2 data", int'(o_data), base + k);
      chk(o_last == (k == n - 1), "R3 last", int'(o_last), int'(k == n - 1));
      chk(io_level == ((n - k) >= th), "R8 level", int'(io_level), int'((n - k) >= th));
      @(posedge clk);
    end
    @(negedge clk);
    o_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(o_valid == 1'b0, "R1 o_valid", int'(o_valid), 0);
    chk(u_ready == 1'b1, "R1 u_ready", int'(u_ready), 1);
    chk(io_empty == 1'b1, "R1 io_empty", int'(io_empty), 1);
    chk(io_full == 1'b0, "R1 io_full", int'(io_full), 0);
    chk(io_level == 1'b0, "R1 io_level", int'(io_level), 0);
    chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    u_valid = 1'b0; u_last = 1'b0; u_data = '0;
    o_ready = 1'b0; cfg_thresh = '0;
    do_reset();

    // R3 every packet length with explicit end, R5/R10 handoff both ways
    for (int len = 1; len <= D; len++) begin
      push(len, len * 32, 1'b1);
      #1;
      chk(o_valid == 1'b1, "R5 commit visible", int'(o_valid), 1);
      chk(io_empty == 1'b0, "R10 empty low", int'(io_empty), 0);
      pop(len, len * 32, len / 2);
      #1;
      chk(io_empty == 1'b1, "R10 empty high", int'(io_empty), 1);
      chk(o_valid == 1'b0, "R5 drained", int'(o_valid), 0);
      chk(u_ready == 1'b1, "R5 returned", int'(u_ready), 1);
    end

    // R4 full buffer commits without end marker
    push(D, 500, 1'b0);
    #1 chk(o_valid == 1'b1, "R4 auto commit", int'(o_valid), 1);
    pop(D, 500, 0);
    push(D, 700, 1'b0);
    push(2, 700 + D, 1'b1);
    pop(D, 700, 3);
    pop(2, 700 + D, 3);

    // R6 ring fill, R7 full, R9 refused write
    push(1, 1000, 1'b1);
    push(2, 2000, 1'b1);
    #1 chk(io_full == 1'b0, "R7 not full", int'(io_full), 0);
    push(3, 3000, 1'b1);
    #1;
    chk(io_full == 1'b1, "R7 full", int'(io_full), 1);
    chk(u_ready == 1'b0, "R7 ready low", int'(u_ready), 0);
    chk(ovf == 1'b0, "R9 ovf before", int'(ovf), 0);
    @(negedge clk);
    u_valid = 1'b1; u_data = 16'hDEAD; u_last = 1'b1;
    @(posedge clk);
    @(negedge clk);
    u_valid = 1'b0; u_last = 1'b0;
    #1;
    chk(ovf == 1'b1, "R9 ovf set", int'(ovf), 1);
    chk(io_full == 1'b1, "R9 nothing stored", int'(io_full), 1);
    pop(1, 1000, 1);
    #1 chk(io_full == 1'b0, "R5 release", int'(io_full), 0);
    pop(2, 2000, 1);
    pop(3, 3000, 1);
    #1;
    chk(io_empty == 1'b1, "R6 ring drained", int'(io_empty), 1);
    chk(ovf == 1'b1, "R9 ovf sticky", int'(ovf), 1);

    // R8 threshold sweep over a full buffer
    for (int th = 0; th <= D + 1; th++) begin
      push(D, th * 16, 1'b1);
      pop(D, th * 16, th);
    end
    cfg_thresh = '0;
    #1 chk(io_level == 1'b0, "R8 level with no data", int'(io_level), 0);

    do_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule